// File: doc/BRIEF.md
# Single-Byte Serial Port with APB Register Access

This block is a two-wire asynchronous serial port (one transmit line, one receive line, no handshake lines) reached through an APB slave. Each direction has exactly one byte of holding storage. Software writes a byte to the data word to queue it for transmission, and reads the same word to collect a received byte. Frames are eight data bits, no parity and one stop bit.

Bit timing comes from one integer divider. It holds the number of system clock cycles per serial bit, so software loads it with the clock frequency divided by the baud rate. Both directions can be enabled on their own. Four interrupt sources exist: transmit, receive, transmit overrun and receive overrun. Each source has its own enable. Pending sources are read and cleared through a single shared word. The transmit source is an event that fires when the holding byte is handed to the shifter. It is not a level that stays high while the buffer is empty.

Top module: `sbuart_apb`

## Requirements
- R1: After reset, the status, control and interrupt words read 0, the divider reads 16, txd is high, and all three interrupt outputs are low.
- R2: Word offsets are: data 0x000, status 0x004, control 0x008, interrupt pending (read) and clear (write) 0x00C, divider 0x010. Control bit meanings are: bit0 transmit on, bit1 receive on, bit2 transmit irq enable, bit3 receive irq enable, bit4 transmit-overrun irq enable, bit5 receive-overrun irq enable, bit6 fast transmit. Control and divider read back as written.
- R3: Transmit frames are one low start bit, eight data bits LSB first and one high stop bit, each lasting max(divider,16) clock cycles. The line idles high.
- R4: A data write while status bit0 (transmit full) is 0 stores the byte and sets bit0. The byte stays held while control bit0 is 0. Once transmission is enabled and the shifter is idle, the shifter takes the byte and bit0 clears.
- R5: A data write while status bit0 is 1 is dropped and sets status bit2 (transmit overrun). Writing 1 to status bit2 clears it.
- R6: Pending bit0 (transmit) sets only on the full-to-empty change of the transmit holding byte, and only while control bit2 is 1. Setting control bit2 while the byte is already empty raises nothing.
- R7: Reading 0x00C returns the pending bits ANDed with their enables. Writing ones to 0x00C clears those pending bits.
- R8: While control bit1 is 1, a received 8N1 frame sampled at mid-bit sets status bit1 (receive full) and pending bit1 when control bit3 is 1. A data read returns the byte and clears status bit1. A frame that arrives while control bit1 is 0 is ignored.
- R9: A frame that completes while status bit1 is 1 is discarded. It sets status bit3 (receive overrun) and, when control bit5 is 1, pending bit3. The held byte is kept. Writing 1 to status bit3 clears it.
- R10: A low pulse on rxd that is high again by the middle of the start bit yields no byte.
- R11: When control bit6 is 1, each transmitted bit lasts one clock cycle.
- R12: irq_tx is enabled pending bit0, irq_rx is enabled pending bit1, and irq_any is the OR of all four enabled pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit event interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_any | output | 1 | OR of all enabled pending interrupts |

## Verification
The hardest state to reach from the ports is a transmit holding byte that stays full long enough to be overwritten. With transmission enabled, the shifter takes the byte one cycle after the write. The stimulus therefore writes two bytes while control bit0 is still clear, which produces the overrun. It then enables transmission and checks three things: the transmit interrupt fires on that hand-over, the serial monitor sees only the first byte, and no interrupt appeared earlier when the enable was set with the buffer empty. Receive overrun is reached by sending two frames back to back without reading, and the receive-side checks confirm that the first byte survives.

// File: rtl/sbuart_pkg.sv
package sbuart_pkg;

    // word indices (byte address >> 2)
    localparam int unsigned WORD_DATA = 0;
    localparam int unsigned WORD_STAT = 1;
    localparam int unsigned WORD_CTRL = 2;
    localparam int unsigned WORD_IRQ  = 3;
    localparam int unsigned WORD_DIV  = 4;

    localparam int unsigned MIN_BIT_CLKS = 16;
    localparam int unsigned FRAME_BITS   = 10;

    // packed so that tx_on is bit 0 and tx_fast is bit 6
    typedef struct packed {
        logic tx_fast;
        logic rxo_ie;
        logic txo_ie;
        logic rx_ie;
        logic tx_ie;
        logic rx_on;
        logic tx_on;
    } ctrl_t;

    // the same bit layout serves status and the pending vector
    typedef struct packed {
        logic rx_ovr;
        logic tx_ovr;
        logic rx_full;
        logic tx_full;
    } flags_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    function automatic logic [31:0] bit_clks(input logic [31:0] div, input logic fast);
        if (fast)
            return 32'd1;
        if (div < MIN_BIT_CLKS)
            return 32'(MIN_BIT_CLKS);
        return div;
    endfunction

endpackage

// File: rtl/sbuart_bit_timer.sv
module sbuart_bit_timer #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    assign tick = run && (cnt == limit - ONE);

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + ONE;
    end

endmodule

// File: rtl/sbuart_tx.sv
module sbuart_tx
    import sbuart_pkg::*;
#(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] div,
    input  logic         fast,
    input  logic         load,
    input  logic [7:0]   load_byte,
    output logic         ready,
    output logic         txd
);
    localparam int unsigned BW = $clog2(FRAME_BITS + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [BW-1:0]         bitn;
    logic                  busy;
    logic                  tick;
    logic [W-1:0]          limit;

    assign limit = W'(bit_clks(32'(div), fast));

    sbuart_bit_timer #(.W(W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (busy),
        .limit (limit),
        .tick  (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
            bitn  <= '0;
            busy  <= 1'b0;
        end else if (load) begin
            shreg <= {1'b1, load_byte, 1'b0};
            bitn  <= '0;
            busy  <= 1'b1;
        end else if (tick) begin
            shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
            bitn  <= bitn + BW'(1);
            if (bitn == LAST_BIT)
                busy <= 1'b0;
        end
    end

    assign ready = !busy;
    assign txd   = busy ? shreg[0] : 1'b1;

    // start bit appears the cycle after a load
    assert_start_low_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> !txd);

    // the register file only hands over a byte to an idle shifter
    assert_load_idle_R4: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);

endmodule

// File: rtl/sbuart_rx.sv
module sbuart_rx
    import sbuart_pkg::*;
#(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] div,
    input  logic         enable,
    input  logic         rxd,
    output logic         valid,
    output logic [7:0]   byte_out
);
    logic [1:0]   sync;
    logic         line;
    rx_state_e    state;
    logic [2:0]   bitn;
    logic [7:0]   shreg;
    logic         tick;
    logic [W-1:0] full_lim;
    logic [W-1:0] limit;

    always_ff @(posedge clk) begin
        if (rst)
            sync <= 2'b11;
        else
            sync <= {sync[0], rxd};
    end
    assign line = sync[1];

    assign full_lim = W'(bit_clks(32'(div), 1'b0));
    assign limit    = (state == RX_START) ? (full_lim >> 1) : full_lim;

    sbuart_bit_timer #(.W(W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (state != RX_IDLE),
        .limit (limit),
        .tick  (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            bitn     <= '0;
            shreg    <= '0;
            valid    <= 1'b0;
            byte_out <= '0;
        end else begin
            valid <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (enable && !line)
                        state <= RX_START;
                end
                RX_START: begin
                    if (tick) begin
                        bitn  <= '0;
                        state <= line ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        shreg <= {line, shreg[7:1]};
                        bitn  <= bitn + 3'd1;
                        if (bitn == 3'd7)
                            state <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (line) begin
                            valid    <= 1'b1;
                            byte_out <= shreg;
                        end
                        state <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // a start that is high at its midpoint never reaches the data phase
    assert_false_start_R10: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && tick && line) |=> state == RX_IDLE);

endmodule

// File: rtl/sbuart_apb.sv
module sbuart_apb
    import sbuart_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DIV_W     = 20,
    parameter int unsigned DIV_RESET = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_any
);
    localparam int unsigned WI_W = ADDR_W - 2;
    localparam int unsigned CTRL_W = $bits(ctrl_t);
    localparam int unsigned FLAG_W = $bits(flags_t);

    logic [WI_W-1:0]  word;
    logic             wr, rd;
    logic             hit_data, hit_stat, hit_ctrl, hit_irq, hit_div;

    ctrl_t            ctrl;
    logic [DIV_W-1:0] div;
    flags_t           st;
    flags_t           pend;
    flags_t           en;
    flags_t           ev;
    flags_t           clr;
    logic [7:0]       tx_hold;
    logic [7:0]       rx_hold;

    logic             tx_ready;
    logic             take;
    logic             tx_acc, tx_drop;
    logic             rx_valid;
    logic [7:0]       rx_byte;
    logic             rx_new, rx_drop;
    logic             rd_data;
    logic             unused_bits;

    assign word     = paddr[ADDR_W-1:2];
    assign wr       = psel && penable && pwrite;
    assign rd       = psel && penable && !pwrite;
    assign hit_data = (word == WI_W'(WORD_DATA));
    assign hit_stat = (word == WI_W'(WORD_STAT));
    assign hit_ctrl = (word == WI_W'(WORD_CTRL));
    assign hit_irq  = (word == WI_W'(WORD_IRQ));
    assign hit_div  = (word == WI_W'(WORD_DIV));

    assign unused_bits = ^{paddr[1:0], pwdata[31:DIV_W]};

    // event sources
    assign take    = ctrl.tx_on && st.tx_full && tx_ready;
    assign tx_acc  = wr && hit_data && !st.tx_full;
    assign tx_drop = wr && hit_data && st.tx_full;
    assign rx_new  = rx_valid && !st.rx_full;
    assign rx_drop = rx_valid && st.rx_full;
    assign rd_data = rd && hit_data;

    assign en  = flags_t'({ctrl.rxo_ie, ctrl.txo_ie, ctrl.rx_ie, ctrl.tx_ie});
    assign ev  = flags_t'({rx_drop, tx_drop, rx_new, take});
    assign clr = (wr && hit_irq) ? flags_t'(pwdata[FLAG_W-1:0]) : flags_t'('0);

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            div  <= DIV_W'(DIV_RESET);
        end else if (wr) begin
            if (hit_ctrl)
                ctrl <= ctrl_t'(pwdata[CTRL_W-1:0]);
            if (hit_div)
                div <= pwdata[DIV_W-1:0];
        end
    end

    // holding bytes and status
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            tx_hold <= '0;
            rx_hold <= '0;
        end else begin
            if (tx_acc) begin
                tx_hold    <= pwdata[7:0];
                st.tx_full <= 1'b1;
            end else if (take) begin
                st.tx_full <= 1'b0;
            end

            if (rx_new) begin
                rx_hold    <= rx_byte;
                st.rx_full <= 1'b1;
            end else if (rd_data) begin
                st.rx_full <= 1'b0;
            end

            if (tx_drop)
                st.tx_ovr <= 1'b1;
            else if (wr && hit_stat && pwdata[2])
                st.tx_ovr <= 1'b0;

            if (rx_drop)
                st.rx_ovr <= 1'b1;
            else if (wr && hit_stat && pwdata[3])
                st.rx_ovr <= 1'b0;
        end
    end

    // pending interrupts: a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else
            pend <= (pend & ~clr) | (ev & en);
    end

    assign irq_tx  = pend.tx_full & en.tx_full;
    assign irq_rx  = pend.rx_full & en.rx_full;
    assign irq_any = |(pend & en);

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (hit_data) prdata[7:0]          = rx_hold;
            if (hit_stat) prdata[FLAG_W-1:0]   = st;
            if (hit_ctrl) prdata[CTRL_W-1:0]   = ctrl;
            if (hit_irq)  prdata[FLAG_W-1:0]   = pend & en;
            if (hit_div)  prdata[DIV_W-1:0]    = div;
            prdata[31] = prdata[31] ^ (unused_bits & 1'b0);
        end
    end

    sbuart_tx #(.W(DIV_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .div       (div),
        .fast      (ctrl.tx_fast),
        .load      (take),
        .load_byte (tx_hold),
        .ready     (tx_ready),
        .txd       (txd)
    );

    sbuart_rx #(.W(DIV_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .div      (div),
        .enable   (ctrl.rx_on),
        .rxd      (rxd),
        .valid    (rx_valid),
        .byte_out (rx_byte)
    );

    assert_take_empties_R4: assert property (@(posedge clk) disable iff (rst)
        take |=> !st.tx_full);

    assert_tx_irq_edge_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pend.tx_full) |-> ($past(st.tx_full) && !st.tx_full));

    assert_rx_byte_fills_R8: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> st.rx_full);

    assert_rx_ovr_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && st.rx_full) |=> ($stable(rx_hold) && st.rx_ovr));

    assert_irq_or_R12: assert property (@(posedge clk) disable iff (rst)
        (irq_tx || irq_rx) |-> irq_any);

endmodule

// File: tb/sbuart_apb_tb.sv
module sbuart_apb_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        rxd = 1'b1;
    logic        txd, irq_tx, irq_rx, irq_any;

    int          n_chk = 0;
    int          n_fail = 0;
    int          mon_p = 16;
    logic [7:0]  tx_exp[$];
    logic [7:0]  rx_exp[$];
    logic [31:0] rv;

    always #5 clk = ~clk;

    sbuart_apb u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rxd(rxd), .txd(txd),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_any(irq_any)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        apb_rd(a, d);
        chk(d == exp, tag, d, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: queue the expected byte, then hand it to the design
    task automatic send_tx(input logic [7:0] b);
        logic [31:0] d;
        do apb_rd(12'h004, d); while (d[0]);
        tx_exp.push_back(b);
        apb_wr(12'h000, {24'h0, b});
    endtask

    task automatic wait_tx_idle();
        logic [31:0] d;
        do apb_rd(12'h004, d); while (d[0]);
        wait_cyc(11 * mon_p + 8);
    endtask

    task automatic send_rx(input logic [7:0] b, input int p, input bit keep);
        if (keep) rx_exp.push_back(b);
        @(negedge clk); rxd = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (p) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (p) @(negedge clk);
    endtask

    task automatic rx_pop_chk(input string tag);
        logic [31:0] d;
        logic [7:0]  e;
        e = (rx_exp.size() > 0) ? rx_exp.pop_front() : 8'hxx;
        apb_rd(12'h000, d);
        chk(d[7:0] === e, tag, d, {24'h0, e});
    endtask

    // monitor: decode frames on txd and compare with the queue (R3)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && txd === 1'b0) begin
                int p;
                logic [7:0] got;
                logic [7:0] exp;
                logic stop_ok;
                p = mon_p;
                repeat (p / 2) @(negedge clk);
                chk(txd === 1'b0, "R3 start bit", {31'h0, txd}, 0);
                for (int j = 0; j < 8; j++) begin
                    repeat (p) @(negedge clk);
                    got[j] = txd;
                end
                repeat (p) @(negedge clk);
                stop_ok = (txd === 1'b1);
                chk(stop_ok, "R3 stop bit", {31'h0, txd}, 1);
                exp = (tx_exp.size() > 0) ? tx_exp.pop_front() : 8'hxx;
                chk(got === exp, "R3 tx byte", {24'h0, got}, {24'h0, exp});
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        wait_cyc(2);

        // R1 reset values
        chk(txd === 1'b1, "R1 txd idle", {31'h0, txd}, 1);
        chk({irq_tx, irq_rx, irq_any} === 3'b000, "R1 irqs low", {29'h0, irq_tx, irq_rx, irq_any}, 0);
        rd_chk(12'h004, 32'h0, "R1 status");
        rd_chk(12'h008, 32'h0, "R1 ctrl");
        rd_chk(12'h00C, 32'h0, "R1 pending");
        rd_chk(12'h010, 32'd16, "R1 divider");

        // R6 enabling tx irq with an empty buffer raises nothing
        apb_wr(12'h008, 32'h04);
        wait_cyc(6);
        chk(irq_tx === 1'b0, "R6 no irq on enable", {31'h0, irq_tx}, 0);

        // R4 byte held while transmit off, R5 overrun drop
        apb_wr(12'h000, 32'hA5);
        rd_chk(12'h004, 32'h1, "R4 tx full held");
        apb_wr(12'h000, 32'h11);
        rd_chk(12'h004, 32'h5, "R5 tx overrun set");
        rd_chk(12'h00C, 32'h0, "R7 masked overrun pending");
        apb_wr(12'h004, 32'h4);
        rd_chk(12'h004, 32'h1, "R5 tx overrun cleared");

        // R6 transmit event on hand-over
        tx_exp.push_back(8'hA5);
        apb_wr(12'h008, 32'h05);
        wait_cyc(3);
        chk(irq_tx === 1'b1, "R6 tx irq on hand-over", {31'h0, irq_tx}, 1);
        chk(irq_any === 1'b1, "R12 any follows tx", {31'h0, irq_any}, 1);
        rd_chk(12'h004, 32'h0, "R4 taken by shifter");
        rd_chk(12'h00C, 32'h1, "R7 pending tx read");
        apb_wr(12'h00C, 32'h1);
        wait_cyc(1);
        chk(irq_tx === 1'b0, "R7 tx pending cleared", {31'h0, irq_tx}, 0);
        wait_tx_idle();

        // R3 several data patterns
        apb_wr(12'h008, 32'h01);
        send_tx(8'h00);
        send_tx(8'hFF);
        send_tx(8'h3C);
        send_tx(8'h81);
        wait_tx_idle();

        // R3 divider clamp and larger divider, R2 readback
        apb_wr(12'h010, 32'd4);
        send_tx(8'h5B);
        wait_tx_idle();
        apb_wr(12'h010, 32'd20);
        mon_p = 20;
        rd_chk(12'h010, 32'd20, "R2 divider readback");
        send_tx(8'hC3);
        wait_tx_idle();

        // R11 fast transmit
        apb_wr(12'h008, 32'h41);
        rd_chk(12'h008, 32'h41, "R2 ctrl readback");
        mon_p = 1;
        send_tx(8'h96);
        send_tx(8'h69);
        wait_tx_idle();
        apb_wr(12'h008, 32'h01);
        apb_wr(12'h010, 32'd16);
        mon_p = 16;

        // R8 receive path
        apb_wr(12'h008, 32'h2B);
        send_rx(8'h5A, 16, 1'b1);
        wait_cyc(4);
        rd_chk(12'h004, 32'h2, "R8 rx full");
        chk(irq_rx === 1'b1, "R12 irq_rx", {31'h0, irq_rx}, 1);
        chk(irq_tx === 1'b0, "R12 irq_tx quiet", {31'h0, irq_tx}, 0);
        rx_pop_chk("R8 rx byte");
        rd_chk(12'h004, 32'h0, "R8 read empties");
        apb_wr(12'h00C, 32'hF);

        // R9 receive overrun
        send_rx(8'h12, 16, 1'b1);
        send_rx(8'h34, 16, 1'b0);
        wait_cyc(4);
        rd_chk(12'h004, 32'hA, "R9 rx overrun status");
        rd_chk(12'h00C, 32'hA, "R9 rx overrun pending");
        rx_pop_chk("R9 first byte kept");
        apb_wr(12'h004, 32'h8);
        rd_chk(12'h004, 32'h0, "R9 overrun cleared");
        apb_wr(12'h00C, 32'hF);
        wait_cyc(1);
        chk(irq_any === 1'b0, "R12 any low after clear", {31'h0, irq_any}, 0);

        // R10 short low pulse
        @(negedge clk); rxd = 1'b0;
        wait_cyc(3);
        rxd = 1'b1;
        wait_cyc(40);
        rd_chk(12'h004, 32'h0, "R10 glitch rejected");

        // R8 receiver off ignores a frame
        apb_wr(12'h008, 32'h01);
        send_rx(8'h77, 16, 1'b0);
        wait_cyc(4);
        rd_chk(12'h004, 32'h0, "R8 rx off ignored");
        rd_chk(12'h000, 32'h12, "R8 rx off data unchanged");

        chk(tx_exp.size() == 0, "R3 all frames seen", tx_exp.size(), 0);
        summary();
        $finish;
    end

endmodule